// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four SRAM Model

This block is a synthesizable model of a synchronous static memory with a dedicated read data path and a dedicated write data path that share one address bus. The address bus is time-shared: one clock cycle is a read slot, the next is a write slot, and the pattern repeats for as long as the block is out of reset. Every address selects a line of four 18-bit words. Any access moves the whole line as a burst of four words.

Double-rate transfer is modelled as two words per clock cycle on 36-bit paths. The lower half of a data bus carries the earlier word and the upper half carries the later word. A write carries its first two words in the cycle of its address and its last two words in the next cycle. Each word has two lane enables, so a write can change some bytes of a line and leave the others as they were. A read returns its line two cycles after the address, over two cycles, and flags those cycles with a valid bit.

Three small state machines do the work. The slot machine toggles between `SLOT_RD` and `SLOT_WR`. The write machine moves `WR_IDLE -> WR_UPPER` when it takes a write address and returns `WR_UPPER -> WR_IDLE` after one cycle, when the merged line is committed. The read machine goes `RD_IDLE -> RD_FETCH` when it takes a read address, then `RD_FETCH -> RD_FIRST`. From `RD_FIRST` it goes to `RD_SECOND_FETCH` if another read is taken in that cycle, or to `RD_SECOND` if none is. It then goes `RD_SECOND_FETCH -> RD_FIRST` and `RD_SECOND -> RD_IDLE`.

Top module: `qb4_sram`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rvalid` is 0 and `rdata` is 0.
- R2: The first cycle after reset is a read slot. Slots then alternate read, write, read, write, one per cycle.
- R3: A read address taken in cycle c makes `rvalid` high in cycles c+2 and c+3. In cycle c+2 `rdata[17:0]` holds word 0 of the line and `rdata[35:18]` holds word 1. In cycle c+3 they hold word 2 and word 3. In every cycle where `rvalid` is low, `rdata` is 0.
- R4: A write taken in cycle w takes word 0 from `wdata[17:0]` and word 1 from `wdata[35:18]` in cycle w. It takes word 2 and word 3 from the same fields in cycle w+1.
- R5: In each write data cycle, `wr_lane_en[0]` enables bits 8:0 and `wr_lane_en[1]` enables bits 17:9 of the word on `wdata[17:0]`. `wr_lane_en[2]` and `wr_lane_en[3]` do the same for the word on `wdata[35:18]`. Bits whose lane enable is 0 keep their old value.
- R6: When `rd_sel_n` is high in a read slot, no read takes place and `rvalid` stays low two and three cycles later.
- R7: When `wr_sel_n` is high in a write slot, no write takes place and the line keeps its contents.
- R8: `rd_sel_n` is ignored in write slots and `wr_sel_n` is ignored in read slots.
- R9: A read taken in the cycle right after a write address to the same line returns the old contents of the line. A read taken one period later returns the new contents.
- R10: A read and a write in the same two-cycle period act independently, including when they target different lines.
- R11: Reads taken in consecutive read slots give an unbroken run of `rvalid`, with the lines in the order the reads were taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read select, sampled in read slots |
| wr_sel_n | input | 1 | Active-low write select, sampled in write slots |
| addr | input | ADDR_W | Line address shared by read and write slots |
| wdata | input | 2*WORD_W | Two write words per cycle, earlier word in the low half |
| wr_lane_en | input | 2*LANES | Per-lane write enables for the two words of this cycle |
| rdata | output | 2*WORD_W | Two read words per cycle, earlier word in the low half |
| rvalid | output | 1 | High in the two cycles that carry a read burst |

## Verification
The bench targets the case where a read lands on a line whose write is still in flight. A design that commits the first half of a write early would return a line that mixes old and new words. Partial lane masks come in both the directed and the random phase, because a design that swaps lanes or words would corrupt bytes that should have kept their old value. Selects are asserted in the wrong slot and back-to-back reads are issued. A design with a broken phase tracker would then start spurious bursts or break the valid run, and a design that reused its fetch register too early would give the second half of a burst the wrong line.

// File: rtl/qb4_pkg.sv
package qb4_pkg;

    typedef enum logic {
        SLOT_RD = 1'b0,
        SLOT_WR = 1'b1
    } slot_e;

    typedef enum logic {
        WR_IDLE  = 1'b0,
        WR_UPPER = 1'b1
    } wr_state_e;

    typedef enum logic [2:0] {
        RD_IDLE         = 3'd0,
        RD_FETCH        = 3'd1,
        RD_FIRST        = 3'd2,
        RD_SECOND_FETCH = 3'd3,
        RD_SECOND       = 3'd4
    } rd_state_e;

endpackage

// File: rtl/qb4_slot_fsm.sv
module qb4_slot_fsm
    import qb4_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot_o
);

    slot_e slot_q;
    slot_e slot_d;

    always_comb begin
        unique case (slot_q)
            SLOT_RD: slot_d = SLOT_WR;
            SLOT_WR: slot_d = SLOT_RD;
            default: slot_d = SLOT_RD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT_RD;
        else        slot_q <= slot_d;
    end

    assign slot_o = slot_q;

    // R2: slots strictly alternate
    p_slot_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_RD) |=> (slot_q == SLOT_WR));
    p_slot_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_WR) |=> (slot_q == SLOT_RD));

endmodule

// File: rtl/qb4_write_ctrl.sv
module qb4_write_ctrl
    import qb4_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 18,
    parameter int LANES  = 2,
    localparam int PAIR_W  = 2 * WORD_W,
    localparam int PMASK_W = 2 * LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  slot_e                slot_i,
    input  logic                 wr_sel_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [PAIR_W-1:0]    wdata_i,
    input  logic [PMASK_W-1:0]   lane_en_i,
    output logic                 commit_o,
    output logic [ADDR_W-1:0]    commit_addr_o,
    output logic [2*PAIR_W-1:0]  commit_data_o,
    output logic [2*PMASK_W-1:0] commit_mask_o
);

    wr_state_e           state_q;
    wr_state_e           state_d;
    logic                take;
    logic [ADDR_W-1:0]   stage_addr_q;
    logic [PAIR_W-1:0]   stage_data_q;
    logic [PMASK_W-1:0]  stage_mask_q;

    // a write address is taken only in write slots with the select low
    assign take = (slot_i == SLOT_WR) && !wr_sel_n;

    always_comb begin
        unique case (state_q)
            WR_IDLE:  state_d = take ? WR_UPPER : WR_IDLE;
            WR_UPPER: state_d = WR_IDLE;
            default:  state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // staging of the first two beats together with their lane enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_addr_q <= '0;
            stage_data_q <= '0;
            stage_mask_q <= '0;
        end else if (state_q == WR_IDLE && take) begin
            stage_addr_q <= addr_i;
            stage_data_q <= wdata_i;
            stage_mask_q <= lane_en_i;
        end
    end

    // the whole line is committed at the end of the second data cycle
    always_comb begin
        commit_o      = (state_q == WR_UPPER);
        commit_addr_o = stage_addr_q;
        commit_data_o = {wdata_i, stage_data_q};
        commit_mask_o = {lane_en_i, stage_mask_q};
    end

    // R4: the second data cycle always falls in a read slot
    p_upper_in_read_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_UPPER) |-> (slot_i == SLOT_RD));
    // R4: a commit is always one cycle after a taken write address
    p_commit_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(take));
    // R7: no commit without a taken address in the cycle before
    p_no_commit_without_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !commit_o);

endmodule

// File: rtl/qb4_line_array.sv
module qb4_line_array #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 18,
    parameter int LANES  = 2,
    parameter int BEATS  = 4,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int LINE_W = WORD_W * BEATS,
    localparam int LANE_W = WORD_W / LANES,
    localparam int NSLICE = LANES * BEATS
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [LINE_W-1:0] wline_i,
    input  logic [NSLICE-1:0] wmask_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [LINE_W-1:0] rline_o
);

    logic [LINE_W-1:0] mem [DEPTH];
    logic [LINE_W-1:0] bit_mask;

    // widen each lane enable to its slice of the line
    for (genvar g = 0; g < NSLICE; g++) begin : g_lane
        assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{wmask_i[g]}};
    end

    // read takes the value before any same-edge write
    always_ff @(posedge clk) begin
        if (we_i)
            mem[waddr_i] <= (mem[waddr_i] & ~bit_mask) | (wline_i & bit_mask);
        if (re_i)
            rline_o <= mem[raddr_i];
    end

endmodule

// File: rtl/qb4_read_ctrl.sv
module qb4_read_ctrl
    import qb4_pkg::*;
#(
    parameter int WORD_W = 18,
    localparam int PAIR_W = 2 * WORD_W,
    localparam int LINE_W = 2 * PAIR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [LINE_W-1:0] line_i,
    output logic              rvalid_o,
    output logic [PAIR_W-1:0] rdata_o
);

    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [PAIR_W-1:0] hold_hi_q;

    always_comb begin
        unique case (state_q)
            RD_IDLE:         state_d = take_i ? RD_FETCH : RD_IDLE;
            RD_FETCH:        state_d = RD_FIRST;
            RD_FIRST:        state_d = take_i ? RD_SECOND_FETCH : RD_SECOND;
            RD_SECOND_FETCH: state_d = RD_FIRST;
            RD_SECOND:       state_d = RD_IDLE;
            default:         state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // output registers: the fetched line is valid in the fetch states
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_o  <= 1'b0;
            rdata_o   <= '0;
            hold_hi_q <= '0;
        end else begin
            unique case (state_q)
                RD_FETCH, RD_SECOND_FETCH: begin
                    rvalid_o  <= 1'b1;
                    rdata_o   <= line_i[PAIR_W-1:0];
                    hold_hi_q <= line_i[LINE_W-1:PAIR_W];
                end
                RD_FIRST: begin
                    rvalid_o <= 1'b1;
                    rdata_o  <= hold_hi_q;
                end
                RD_IDLE, RD_SECOND: begin
                    rvalid_o <= 1'b0;
                    rdata_o  <= '0;
                end
                default: begin
                    rvalid_o <= 1'b0;
                    rdata_o  <= '0;
                end
            endcase
        end
    end

    // R3: a taken read gives valid data two and three cycles later
    p_valid_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> ##1 rvalid_o ##1 rvalid_o);
    // R6: valid only appears as the result of a taken read
    p_valid_has_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> ($past(take_i, 2) || $past(take_i, 3)));
    // R3: data is zero outside bursts
    p_idle_data_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> (rdata_o == '0));
    // R11: a second read in the first-beat cycle keeps valid unbroken
    p_back_to_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_SECOND_FETCH) |=> rvalid_o);

endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
    import qb4_pkg::*;
#(
    parameter int ADDR_W = 6,   // 17 gives the full-size array
    parameter int WORD_W = 18,
    parameter int LANES  = 2,
    localparam int BEATS   = 4,
    localparam int PAIR_W  = 2 * WORD_W,
    localparam int PMASK_W = 2 * LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_sel_n,
    input  logic               wr_sel_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [PAIR_W-1:0]  wdata,
    input  logic [PMASK_W-1:0] wr_lane_en,
    output logic [PAIR_W-1:0]  rdata,
    output logic               rvalid
);

    slot_e                slot;
    logic                 rd_take;
    logic                 commit;
    logic [ADDR_W-1:0]    commit_addr;
    logic [2*PAIR_W-1:0]  commit_data;
    logic [2*PMASK_W-1:0] commit_mask;
    logic [2*PAIR_W-1:0]  fetched_line;

    qb4_slot_fsm u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot)
    );

    // a read address is taken only in read slots with the select low
    assign rd_take = rst_n && (slot == SLOT_RD) && !rd_sel_n;

    qb4_write_ctrl #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .LANES  (LANES)
    ) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_i        (slot),
        .wr_sel_n      (wr_sel_n),
        .addr_i        (addr),
        .wdata_i       (wdata),
        .lane_en_i     (wr_lane_en),
        .commit_o      (commit),
        .commit_addr_o (commit_addr),
        .commit_data_o (commit_data),
        .commit_mask_o (commit_mask)
    );

    qb4_line_array #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .BEATS  (BEATS)
    ) u_array (
        .clk     (clk),
        .we_i    (commit),
        .waddr_i (commit_addr),
        .wline_i (commit_data),
        .wmask_i (commit_mask),
        .re_i    (rd_take),
        .raddr_i (addr),
        .rline_o (fetched_line)
    );

    qb4_read_ctrl #(
        .WORD_W (WORD_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (rd_take),
        .line_i   (fetched_line),
        .rvalid_o (rvalid),
        .rdata_o  (rdata)
    );

    // R8: a read is never taken in a write slot
    p_read_only_in_read_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |-> (slot == SLOT_RD));
    // R8: a commit never follows a read slot
    p_commit_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(slot == SLOT_WR));

endmodule

// File: tb/qb4_sram_tb.sv
module qb4_sram_tb;

    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MAXC   = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_sel_n = 1'b1;
    logic        wr_sel_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [35:0] wdata = '0;
    logic [3:0]  wr_lane_en = '0;
    logic [35:0] rdata;
    logic        rvalid;

    int checks = 0;
    int fails  = 0;
    int m      = 0;

    bit [71:0] mm [DEPTH];
    bit        exp_v [MAXC];
    bit [35:0] exp_d [MAXC];
    string     exp_t [MAXC];
    bit        pend = 0;
    bit [5:0]  pa;
    bit [35:0] plo;
    bit [3:0]  plm;
    bit [35:0] carry_d = '0;
    bit [3:0]  carry_l = '0;

    qb4_sram #(.ADDR_W(ADDR_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_sel_n   (rd_sel_n),
        .wr_sel_n   (wr_sel_n),
        .addr       (addr),
        .wdata      (wdata),
        .wr_lane_en (wr_lane_en),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    always #10 clk = ~clk;

    function automatic bit [71:0] merge(bit [71:0] old, bit [71:0] nw, bit [7:0] msk);
        bit [71:0] r = old;
        for (int g = 0; g < 8; g++)
            if (msk[g]) r[g*9 +: 9] = nw[g*9 +: 9];
        return r;
    endfunction

    function automatic bit [71:0] pattern(int line, int salt);
        bit [71:0] r;
        for (int w = 0; w < 4; w++)
            r[w*18 +: 18] = 18'((line * 977 + w * 131 + salt * 7919) & 18'h3ffff);
        return r;
    endfunction

    // one cycle: check outputs of this cycle, drive inputs, update the model
    task automatic step(input bit rs_n, input bit ws_n, input bit [5:0] a,
                        input bit [35:0] wd, input bit [3:0] ln, input string tag);
        checks++;
        if (rvalid !== exp_v[m] || rdata !== exp_d[m]) begin
            fails++;
            $display("FAIL %s cycle %0d: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     exp_v[m] ? exp_t[m] : tag, m, rvalid, rdata, exp_v[m], exp_d[m]);
        end
        rd_sel_n = rs_n; wr_sel_n = ws_n; addr = a; wdata = wd; wr_lane_en = ln;
        if (!m[0] && !rs_n) begin
            exp_v[m+2] = 1'b1; exp_d[m+2] = mm[a][35:0];  exp_t[m+2] = tag;
            exp_v[m+3] = 1'b1; exp_d[m+3] = mm[a][71:36]; exp_t[m+3] = tag;
        end
        if (pend) begin
            mm[pa] = merge(mm[pa], {wd, plo}, {ln, plm});
            pend = 1'b0;
        end
        if (m[0] && !ws_n) begin
            pend = 1'b1; pa = a; plo = wd; plm = ln;
        end
        @(negedge clk);
        m++;
    endtask

    // one read slot then one write slot; upper write words go out next period
    task automatic period(input bit rs_n, input bit [5:0] ra, input bit ws_n,
                          input bit [5:0] wa, input bit [71:0] wl, input bit [7:0] wm,
                          input string tag);
        step(rs_n, 1'b1, ra, carry_d, carry_l, tag);
        step(1'b1, ws_n, wa, wl[35:0], wm[3:0], tag);
        carry_d = wl[71:36];
        carry_l = wm[7:4];
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin : main
        int unsigned r;
        r = $urandom(32'd4711);
        for (int i = 0; i < MAXC; i++) begin exp_v[i] = 0; exp_d[i] = '0; exp_t[i] = ""; end

        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        checks++;
        if (rvalid !== 1'b0 || rdata !== '0) begin
            fails++;
            $display("FAIL R1 reset: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
        end
        rst_n = 1'b1;

        // R2 R4: fill every line with full masks, first slot after reset is a read slot
        for (int l = 0; l < DEPTH; l++)
            period(1'b1, 6'd0, 1'b0, 6'(l), pattern(l, 1), 8'hff, "R4");
        period(1'b1, 6'd0, 1'b1, 6'd0, '0, '0, "R2");

        // R3 R2: read back a few lines
        for (int l = 0; l < 6; l++)
            period(1'b0, 6'(l * 11), 1'b1, 6'd0, '0, '0, "R3");
        period(1'b1, 6'd0, 1'b1, 6'd0, '0, '0, "R3");
        period(1'b1, 6'd0, 1'b1, 6'd0, '0, '0, "R3");

        // R9: write line 5, read it in the very next slot (old) and one period later (new)
        period(1'b1, 6'd0, 1'b0, 6'd5, pattern(5, 2), 8'hff, "R9");
        period(1'b0, 6'd5, 1'b1, 6'd0, '0, '0, "R9");
        period(1'b0, 6'd5, 1'b1, 6'd0, '0, '0, "R9");
        period(1'b1, 6'd0, 1'b1, 6'd0, '0, '0, "R9");

        // R5: partial lane masks on line 7
        period(1'b1, 6'd0, 1'b0, 6'd7, {4{18'h3ffff}}, 8'b1001_0110, "R5");
        period(1'b1, 6'd0, 1'b1, 6'd0, '0, '0, "R5");
        period(1'b0, 6'd7, 1'b1, 6'd0, '0, '0, "R5");
        period(1'b1, 6'd0, 1'b1, 6'd0, '0, '0, "R5");

        // R6 R7: deselected slots
        period(1'b1, 6'd9, 1'b1, 6'd9, {4{18'h15555}}, 8'hff, "R7");
        period(1'b1, 6'd9, 1'b1, 6'd0, '0, '0, "R6");
        period(1'b0, 6'd9, 1'b1, 6'd0, '0, '0, "R7");
        period(1'b1, 6'd0, 1'b1, 6'd0, '0, '0, "R6");

        // R8: selects low in the opposite slot
        step(1'b1, 1'b0, 6'd12, 36'h0_aaaa_5555, 4'hf, "R8");
        step(1'b0, 1'b1, 6'd12, 36'h5_5555_aaaa, 4'hf, "R8");
        step(1'b1, 1'b1, 6'd0, '0, '0, "R8");
        step(1'b1, 1'b1, 6'd0, '0, '0, "R8");
        period(1'b0, 6'd12, 1'b1, 6'd0, '0, '0, "R8");
        period(1'b1, 6'd0, 1'b1, 6'd0, '0, '0, "R8");

        // R10 R11: concurrent read and write, back-to-back reads
        period(1'b0, 6'd20, 1'b0, 6'd21, pattern(21, 3), 8'hff, "R10");
        period(1'b0, 6'd21, 1'b0, 6'd20, pattern(20, 3), 8'h3c, "R11");
        period(1'b0, 6'd20, 1'b1, 6'd0, '0, '0, "R11");
        period(1'b0, 6'd21, 1'b1, 6'd0, '0, '0, "R11");
        period(1'b1, 6'd0, 1'b1, 6'd0, '0, '0, "R11");

        // R3 R5 R9 R10: constrained random traffic on a narrow address range
        for (int i = 0; i < 1500; i++) begin
            bit rs, ws;
            bit [5:0] ra, wa;
            bit [71:0] wl;
            rs = ($urandom % 10) < 3;
            ws = ($urandom % 10) < 3;
            ra = 6'($urandom % 16);
            wa = 6'($urandom % 16);
            wl = {8'($urandom), 32'($urandom), 32'($urandom)};
            period(rs, ra, ws, wa, wl, 8'($urandom), "R10");
        end
        for (int i = 0; i < 4; i++)
            period(1'b1, 6'd0, 1'b1, 6'd0, '0, '0, "R3");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule